// File: doc/BRIEF.md
# Multiply-Accumulate Register Peripheral

This block is a multiply/add engine that sits on the byte-wide special-function-register bus of an 8-bit microcontroller. Software loads two 16-bit operands (A and B) and a 32-bit addend (C) one byte at a time. It then writes an operation code to a mode register, which starts the operation. The engine either multiplies A by B, or adds the 32-bit word {A, B} (A in the upper half) to C, to the previous result, or to zero. Every completed operation stores its result in a result register and copies it into a previous-result register (PREV), so that running sums can be built.

A second control register holds an interrupt enable and two sticky overflow flags, one for 16-bit and one for 32-bit overflow. It also accepts a 3-bit clear command. The command can wipe a single data register, all data registers together with the flags, or only the flags. When the 32-bit flag is raised, the wrapped 32-bit sum is also captured in a dedicated overflow register. The interrupt line is the 32-bit flag gated by the enable.

Top module: `macUnit`

## Requirements
- R1: After reset, every data register (A, B, C, result, PREV, overflow capture), both flags, the interrupt enable and the mode are zero, and the interrupt output is low.
- R2: Bytes written to A (F2h low, F3h high), B (F9h low, FAh high) and C (ECh..EFh, lowest byte first) read back at the same addresses. Result reads at E0h..E3h, PREV at E4h..E7h and the overflow capture at E8h..EBh, lowest byte first. Any unmapped address reads 00h.
- R3: Writing 00 to bits 1:0 of the mode register at F4h multiplies A by B as unsigned numbers. The 32-bit product lands in the result and in PREV two rising edges after the write is presented.
- R4: Mode 01 adds {A,B}+C, mode 10 adds {A,B}+PREV and mode 11 adds {A,B}+0. The sum is taken modulo 2^32 and lands in the result and in PREV with the same latency as R3.
- R5: The 16-bit overflow flag (control bit 1) is set when a product does not fit in 16 bits, or when an add carries out of bit 15.
- R6: The 32-bit overflow flag (control bit 0) is set on an unsigned carry out of bit 31 of an add, and the wrapped sum is then captured in the overflow register.
- R7: Both flags are sticky. Later operations that do not overflow leave them set.
- R8: A write to the control register at F1h with bits 7:5 equal to 001, 010, 011 or 100 clears A, B, C or PREV respectively, one cycle after the write takes effect. Other registers are unchanged. Code 000 and code 111 change nothing.
- R9: Clear code 101 zeroes A, B, C, PREV, the result, the overflow register and both flags. Code 110 zeroes only the two flags.
- R10: The control register reads as {000, enable, 00, flag16, flag32}. The clear bits always read 0, and bit 4 stores the written interrupt enable.
- R11: The interrupt output is high exactly when the 32-bit flag and the enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register byte address |
| busWrEn | input | 1 | Write strobe for the addressed byte |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr (combinational) |
| macIrq | output | 1 | Overflow interrupt request |

## Verification
An operand or enable byte is stored on the rising edge that samples the write. A started operation or a clear command is acted on at the following rising edge. Every bench write therefore holds the strobe for one cycle and then idles for one more cycle before any read is scored. Reads are combinational, so each expected byte is pushed into a scoreboard queue and compared a quarter period after the falling edge, clear of any active edge. A separate check reads A at the falling edge just after the clear command is sampled, to confirm the old value is still present, and reads it again one edge later to confirm it is zero.

// File: rtl/macUnitPkg.sv
package macUnitPkg;

  localparam int unsigned BYTE_W = 8;

  localparam logic [7:0] ADDR_CTRL2  = 8'hF1;
  localparam logic [7:0] ADDR_MODE   = 8'hF4;
  localparam logic [7:0] ADDR_A_BASE = 8'hF2;
  localparam logic [7:0] ADDR_B_BASE = 8'hF9;
  localparam logic [7:0] ADDR_C_BASE = 8'hEC;
  localparam logic [7:0] ADDR_R_BASE = 8'hE0;
  localparam logic [7:0] ADDR_P_BASE = 8'hE4;
  localparam logic [7:0] ADDR_O_BASE = 8'hE8;

  typedef enum logic [1:0] {
    OP_MUL     = 2'b00,
    OP_ADDC    = 2'b01,
    OP_ADDPREV = 2'b10,
    OP_ADDZERO = 2'b11
  } opSel_e;

  typedef enum logic [2:0] {
    CLR_NONE  = 3'b000,
    CLR_A     = 3'b001,
    CLR_B     = 3'b010,
    CLR_C     = 3'b011,
    CLR_PREV  = 3'b100,
    CLR_ALL   = 3'b101,
    CLR_FLAGS = 3'b110,
    CLR_RSVD  = 3'b111
  } clrCmd_e;

  typedef struct packed {
    logic [1:0]        wrA;
    logic [1:0]        wrB;
    logic [3:0]        wrC;
    logic [BYTE_W-1:0] wrData;
    logic              startOp;
    opSel_e            opSel;
    logic              clrA;
    logic              clrB;
    logic              clrC;
    logic              clrPrev;
    logic              clrAll;
    logic              clrFlags;
  } macStrobe_t;

endpackage

// File: rtl/macCtrl.sv
module macCtrl
  import macUnitPkg::*;
#(
  parameter int unsigned OPW = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  busAddr,
  input  logic        busWrEn,
  input  logic [7:0]  busWrData,
  output macStrobe_t  strobe,
  output logic        intEnable,
  output logic [1:0]  modeReg
);

  localparam int unsigned OPB  = OPW / BYTE_W;
  localparam int unsigned ACCB = 2 * OPB;

  logic     wrCtrl2;
  logic     wrMode;
  clrCmd_e  pendClr;
  logic     pendStart;
  logic [OPB-1:0]  hitA;
  logic [OPB-1:0]  hitB;
  logic [ACCB-1:0] hitC;

  assign wrCtrl2 = busWrEn && (busAddr == ADDR_CTRL2);
  assign wrMode  = busWrEn && (busAddr == ADDR_MODE);

  for (genvar i = 0; i < OPB; i++) begin : g_opHit
    assign hitA[i] = busWrEn && (busAddr == ADDR_A_BASE + 8'(i));
    assign hitB[i] = busWrEn && (busAddr == ADDR_B_BASE + 8'(i));
  end

  for (genvar i = 0; i < ACCB; i++) begin : g_accHit
    assign hitC[i] = busWrEn && (busAddr == ADDR_C_BASE + 8'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendClr   <= CLR_NONE;
      pendStart <= 1'b0;
      intEnable <= 1'b0;
      modeReg   <= 2'b00;
    end else begin
      pendClr   <= wrCtrl2 ? clrCmd_e'(busWrData[7:5]) : CLR_NONE;
      pendStart <= wrMode;
      if (wrCtrl2) intEnable <= busWrData[4];
      if (wrMode)  modeReg   <= busWrData[1:0];
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.wrA      = hitA;
    strobe.wrB      = hitB;
    strobe.wrC      = hitC;
    strobe.wrData   = busWrData;
    strobe.startOp  = pendStart;
    strobe.opSel    = opSel_e'(modeReg);
    strobe.clrA     = (pendClr == CLR_A);
    strobe.clrB     = (pendClr == CLR_B);
    strobe.clrC     = (pendClr == CLR_C);
    strobe.clrPrev  = (pendClr == CLR_PREV);
    strobe.clrAll   = (pendClr == CLR_ALL);
    strobe.clrFlags = (pendClr == CLR_FLAGS);
  end

  // R8
  clr_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clrA, strobe.clrB, strobe.clrC, strobe.clrPrev,
              strobe.clrAll, strobe.clrFlags, strobe.startOp}));

  // R10
  int_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrl2 |=> (intEnable == $past(busWrData[4])));

endmodule

// File: rtl/macDatapath.sv
module macDatapath
  import macUnitPkg::*;
#(
  parameter int unsigned OPW = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  macStrobe_t  strobe,
  input  logic [7:0]  busAddr,
  input  logic        intEnable,
  input  logic [1:0]  modeReg,
  output logic [7:0]  busRdData,
  output logic        flag32
);

  localparam int unsigned OPB  = OPW / BYTE_W;
  localparam int unsigned ACCW = 2 * OPW;
  localparam int unsigned ACCB = ACCW / BYTE_W;

  logic [OPW-1:0]  opA;
  logic [OPW-1:0]  opB;
  logic [ACCW-1:0] opC;
  logic [ACCW-1:0] prevReg;
  logic [ACCW-1:0] resultReg;
  logic [ACCW-1:0] ovReg;
  logic            flag16;

  logic [ACCW-1:0] addend;
  logic [ACCW:0]   sumWide;
  logic [ACCW-1:0] product;
  logic            carry16;
  logic [ACCW-1:0] opResult;
  logic            ov16Set;
  logic            ov32Set;

  always_comb begin
    unique case (strobe.opSel)
      OP_ADDC:    addend = opC;
      OP_ADDPREV: addend = prevReg;
      default:    addend = '0;
    endcase
    sumWide = {1'b0, opA, opB} + {1'b0, addend};
    carry16 = sumWide[OPW] ^ opA[0] ^ addend[OPW];
    product = ACCW'(opA) * ACCW'(opB);
    if (strobe.opSel == OP_MUL) begin
      opResult = product;
      ov16Set  = |product[ACCW-1:OPW];
      ov32Set  = 1'b0;
    end else begin
      opResult = sumWide[ACCW-1:0];
      ov16Set  = carry16;
      ov32Set  = sumWide[ACCW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opA       <= '0;
      opB       <= '0;
      opC       <= '0;
      prevReg   <= '0;
      resultReg <= '0;
      ovReg     <= '0;
      flag16    <= 1'b0;
      flag32    <= 1'b0;
    end else begin
      for (int i = 0; i < OPB; i++) begin
        if (strobe.wrA[i]) opA[i*BYTE_W +: BYTE_W] <= strobe.wrData;
        if (strobe.wrB[i]) opB[i*BYTE_W +: BYTE_W] <= strobe.wrData;
      end
      for (int i = 0; i < ACCB; i++) begin
        if (strobe.wrC[i]) opC[i*BYTE_W +: BYTE_W] <= strobe.wrData;
      end
      if (strobe.startOp) begin
        resultReg <= opResult;
        prevReg   <= opResult;
        if (ov16Set) flag16 <= 1'b1;
        if (ov32Set) begin
          flag32 <= 1'b1;
          ovReg  <= sumWide[ACCW-1:0];
        end
      end
      if (strobe.clrA)    opA     <= '0;
      if (strobe.clrB)    opB     <= '0;
      if (strobe.clrC)    opC     <= '0;
      if (strobe.clrPrev) prevReg <= '0;
      if (strobe.clrFlags) begin
        flag16 <= 1'b0;
        flag32 <= 1'b0;
      end
      if (strobe.clrAll) begin
        opA       <= '0;
        opB       <= '0;
        opC       <= '0;
        prevReg   <= '0;
        resultReg <= '0;
        ovReg     <= '0;
        flag16    <= 1'b0;
        flag32    <= 1'b0;
      end
    end
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == ADDR_CTRL2)
      busRdData = {3'b000, intEnable, 2'b00, flag16, flag32};
    if (busAddr == ADDR_MODE)
      busRdData = {6'b0, modeReg};
    for (int i = 0; i < OPB; i++) begin
      if (busAddr == ADDR_A_BASE + 8'(i)) busRdData = opA[i*BYTE_W +: BYTE_W];
      if (busAddr == ADDR_B_BASE + 8'(i)) busRdData = opB[i*BYTE_W +: BYTE_W];
    end
    for (int i = 0; i < ACCB; i++) begin
      if (busAddr == ADDR_C_BASE + 8'(i)) busRdData = opC[i*BYTE_W +: BYTE_W];
      if (busAddr == ADDR_R_BASE + 8'(i)) busRdData = resultReg[i*BYTE_W +: BYTE_W];
      if (busAddr == ADDR_P_BASE + 8'(i)) busRdData = prevReg[i*BYTE_W +: BYTE_W];
      if (busAddr == ADDR_O_BASE + 8'(i)) busRdData = ovReg[i*BYTE_W +: BYTE_W];
    end
  end

  // R3
  mul_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.startOp && strobe.opSel == OP_MUL) |=>
      (resultReg == $past(ACCW'(opA) * ACCW'(opB))) && (prevReg == resultReg));

  // R6
  ovreg_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag32) |-> (ovReg == resultReg));

  // R7
  ov_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flag32 && flag16 && !strobe.clrAll && !strobe.clrFlags) |=> (flag32 && flag16));

  // R8
  clear_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrA |=> (opA == '0));

  // R9
  clear_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrAll |=> (!flag16 && !flag32 && resultReg == '0 && ovReg == '0));

endmodule

// File: rtl/macUnit.sv
module macUnit
  import macUnitPkg::*;
#(
  parameter int unsigned OPW = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] busAddr,
  input  logic       busWrEn,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  output logic       macIrq
);

  macStrobe_t strobe;
  logic       intEnable;
  logic [1:0] modeReg;
  logic       flag32;

  macCtrl #(.OPW(OPW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .strobe    (strobe),
    .intEnable (intEnable),
    .modeReg   (modeReg)
  );

  macDatapath #(.OPW(OPW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busAddr   (busAddr),
    .intEnable (intEnable),
    .modeReg   (modeReg),
    .busRdData (busRdData),
    .flag32    (flag32)
  );

  assign macIrq = flag32 & intEnable;

endmodule

// File: tb/macUnit_test.sv
module macUnit_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic       macIrq;

  always #10 clk = ~clk;

  macUnit uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .macIrq(macIrq)
  );

  typedef struct {
    logic [7:0] addr;
    logic [7:0] exp;
    bit         isIrq;
    string      tag;
  } item_t;

  item_t  sbQueue[$];
  event   sampleEv;
  int     checks = 0;
  int     errors = 0;
  bit     finished = 0;

  logic [15:0] mA = 0, mB = 0;
  logic [31:0] mC = 0, mPrev = 0, mRes = 0, mOv = 0;
  bit          f16 = 0, f32 = 0, ie = 0;

  always begin
    @(sampleEv);
    while (sbQueue.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sbQueue.pop_front();
      act = it.isIrq ? {7'b0, macIrq} : busRdData;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s addr=%02h actual=%02h expected=%02h", it.tag, it.addr, act, it.exp);
      end
    end
  end

  task automatic pushNow(input logic [7:0] a, input logic [7:0] e, input bit irq, input string tag);
    item_t it;
    busAddr = a;
    it.addr = a; it.exp = e; it.isIrq = irq; it.tag = tag;
    sbQueue.push_back(it);
    #5;
    ->sampleEv;
    #1;
  endtask

  task automatic expectByte(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    pushNow(a, e, 1'b0, tag);
  endtask

  task automatic expectIrq(input bit e, input string tag);
    @(negedge clk);
    pushNow(8'h00, {7'b0, e}, 1'b1, tag);
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect32(input logic [7:0] base, input logic [31:0] v, input string tag);
    for (int i = 0; i < 4; i++) expectByte(base + 8'(i), v[i*8 +: 8], tag);
  endtask

  task automatic checkAll(input string tag);
    expectByte(8'hF2, mA[7:0], tag);
    expectByte(8'hF3, mA[15:8], tag);
    expectByte(8'hF9, mB[7:0], tag);
    expectByte(8'hFA, mB[15:8], tag);
    expect32(8'hEC, mC, tag);
    expect32(8'hE0, mRes, tag);
    expect32(8'hE4, mPrev, tag);
    expect32(8'hE8, mOv, tag);
    expectByte(8'hF1, {3'b000, ie, 2'b00, f16, f32}, tag);
    expectIrq(f32 & ie, tag);
  endtask

  task automatic setA(input logic [15:0] v);
    writeReg(8'hF2, v[7:0]); writeReg(8'hF3, v[15:8]); mA = v;
  endtask

  task automatic setB(input logic [15:0] v);
    writeReg(8'hF9, v[7:0]); writeReg(8'hFA, v[15:8]); mB = v;
  endtask

  task automatic setC(input logic [31:0] v);
    for (int i = 0; i < 4; i++) writeReg(8'hEC + 8'(i), v[i*8 +: 8]);
    mC = v;
  endtask

  task automatic runOp(input logic [1:0] mode);
    logic [31:0] addend;
    logic [32:0] sum;
    logic [16:0] low;
    writeReg(8'hF4, {6'b0, mode});
    if (mode == 2'b00) begin
      mRes = {16'b0, mA} * {16'b0, mB};
      if (mRes[31:16] != 0) f16 = 1;
    end else begin
      addend = (mode == 2'b01) ? mC : (mode == 2'b10) ? mPrev : 32'h0;
      sum = {1'b0, mA, mB} + {1'b0, addend};
      low = {1'b0, mB} + {1'b0, addend[15:0]};
      mRes = sum[31:0];
      if (low[16]) f16 = 1;
      if (sum[32]) begin f32 = 1; mOv = sum[31:0]; end
    end
    mPrev = mRes;
  endtask

  task automatic clearCmd(input logic [2:0] cmd);
    writeReg(8'hF1, {cmd, ie, 4'b0000});
    case (cmd)
      3'b001: mA = 0;
      3'b010: mB = 0;
      3'b011: mC = 0;
      3'b100: mPrev = 0;
      3'b101: begin mA = 0; mB = 0; mC = 0; mPrev = 0; mRes = 0; mOv = 0; f16 = 0; f32 = 0; end
      3'b110: begin f16 = 0; f32 = 0; end
      default: ;
    endcase
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    checkAll("R1");
    expectByte(8'hF4, 8'h00, "R1");

    // R2 readback and unmapped address
    setA(16'h1234); setB(16'h5678); setC(32'h89ABCDEF);
    checkAll("R2");
    expectByte(8'hF0, 8'h00, "R2");
    expectByte(8'hFB, 8'h00, "R2");

    // R3 and R5: large product sets 16-bit flag
    runOp(2'b00);
    checkAll("R3_R5");

    // R4 add with C (carry out of bit 15)
    runOp(2'b01);
    checkAll("R4");

    // R9 flags-only clear
    clearCmd(3'b110);
    checkAll("R9");

    // R3 small product, R4 other add sources
    setA(16'h0003); setB(16'h0005);
    runOp(2'b00);
    checkAll("R3");
    runOp(2'b10);
    checkAll("R4");
    runOp(2'b11);
    checkAll("R4");

    // R6 32-bit carry, capture of wrapped sum
    setA(16'hFFFF); setB(16'hFFFF); setC(32'h00000002);
    runOp(2'b01);
    checkAll("R6");

    // R10 and R11: enable interrupt
    ie = 1;
    clearCmd(3'b000);
    checkAll("R10_R11");

    // R7 sticky flags across non-overflowing ops
    setA(16'h0002); setB(16'h0003);
    runOp(2'b00);
    runOp(2'b11);
    checkAll("R7");

    // R8 clear timing: A still held one edge after command sampled
    @(negedge clk);
    busAddr = 8'hF1; busWrData = {3'b001, ie, 4'b0000}; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    pushNow(8'hF2, mA[7:0], 1'b0, "R8");
    mA = 0;
    @(negedge clk);
    pushNow(8'hF2, 8'h00, 1'b0, "R8");
    checkAll("R8");

    // R8 remaining individual clears and reserved code
    clearCmd(3'b010); checkAll("R8");
    clearCmd(3'b011); checkAll("R8");
    clearCmd(3'b100); checkAll("R8");
    setA(16'hABCD); setC(32'h01020304);
    clearCmd(3'b111); checkAll("R8");

    // R9 clear everything, enable kept
    setB(16'h1111);
    runOp(2'b01);
    clearCmd(3'b101);
    checkAll("R9");

    @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule